// File: doc/BRIEF.md
# Three-Operand Option-Encoded Bitwise Logic Unit

This block computes one bitwise boolean function of three equal-width operands A, B and C. A six-bit option word picks the function. It does so through a fixed chain of gate stages, not through a full truth table. The low three option bits invert the operands one by one. An AND of the conditioned A and B forms a product, which can be inverted. That product is then gated with the conditioned C, and the result can be inverted again. The top option bit and the two bits beside it choose how the final result is formed: the gated chain, a three-way XOR, a product-XOR-C form, or a per-bit select.

Each bit position is computed on its own, so the operand width is only a matter of replication. By default the result is captured in an output register one cycle after a valid strobe, together with a matching output valid. A parameter can remove the register and give a purely combinational path.

Top module: `tri_logic_unit`

## Requirements
- R1: Option bit 0 inverts A, bit 1 inverts B and bit 2 inverts C before any other stage. The conditioned operands are called A1, B1 and C1.
- R2: With option bit 5 set, the result is ((A1 AND B1) XOR bit3) AND C1, then XORed with bit 4. Bit 3 inverts the product and bit 4 inverts the gated value.
- R3: With option bit 5 clear and bits 4 and 3 both set, the result is A1 XOR B1 XOR C1.
- R4: With option bit 5 clear, bit 4 set and bit 3 clear, the result is (A1 AND B1) XOR C1. The product is used without inversion.
- R5: With option bits 5 and 4 both clear, the result is (A1 AND B1) OR (NOT A1 AND C1). With the low three bits clear, this is a per-bit select: B where A is 1, C where A is 0.
- R6: With option bits 5 and 4 both clear, option bit 3 has no effect on the result.
- R7: Each result bit depends only on the operand bits at the same position.
- R8: In the registered variant, out_valid equals in_valid from the previous cycle. out_result loads the computed value on a cycle with in_valid high and holds its value on cycles with in_valid low.
- R9: While rst is high at a clock edge, out_valid and out_result are cleared to zero.
- R10: Writing the option word with bit 5 as its most significant bit, 0b100000 gives A&B&C, 0b110111 gives A|B|C and 0b011001 gives NOT(A^B^C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and option word are valid this cycle |
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| opnd_c | input | WIDTH | Operand C |
| op_sel | input | 6 | Option word selecting the function |
| out_valid | output | 1 | Result valid |
| out_result | output | WIDTH | Bitwise result |

## Verification
The assertions assume that the operands and the option word carry known values on every cycle where in_valid is high. They also assume that the output register is the default variant, so that results appear exactly one edge later. The bench drives every input only on falling clock edges and never leaves an unknown value on a bus while the strobe is high. It also drives changing, non-zero garbage while the strobe is low, so the hold behaviour is observed at the ports and not assumed.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    localparam int unsigned DEF_WIDTH = 64;
    localparam int unsigned OPT_BITS  = 6;

    // Option word, most significant field first.
    typedef struct packed {
        logic gate_path;   // bit 5: take the gated chain result
        logic flip_gate;   // bit 4
        logic flip_prod;   // bit 3
        logic flip_c;      // bit 2
        logic flip_b;      // bit 1
        logic flip_a;      // bit 0
    } opt_t;

    typedef enum logic [1:0] {
        MODE_SELECT = 2'd0,
        MODE_PXC    = 2'd1,
        MODE_XOR3   = 2'd2,
        MODE_GATED  = 2'd3
    } mode_e;

    function automatic mode_e decode_mode(opt_t o);
        mode_e m;
        if (o.gate_path)       m = MODE_GATED;
        else if (!o.flip_gate) m = MODE_SELECT;
        else if (o.flip_prod)  m = MODE_XOR3;
        else                   m = MODE_PXC;
        return m;
    endfunction

    function automatic logic cond_bit(logic v, logic flip);
        return v ^ flip;
    endfunction

endpackage

// File: rtl/tlu_operand_cond.sv
module tlu_operand_cond #(
    parameter int unsigned WIDTH = tlu_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    input  tlu_pkg::opt_t    opt,
    output logic [WIDTH-1:0] a1,
    output logic [WIDTH-1:0] b1,
    output logic [WIDTH-1:0] c1
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_cond
        always_comb begin
            a1[i] = tlu_pkg::cond_bit(a[i], opt.flip_a);
            b1[i] = tlu_pkg::cond_bit(b[i], opt.flip_b);
            c1[i] = tlu_pkg::cond_bit(c[i], opt.flip_c);
        end
    end
endmodule

// File: rtl/tlu_combine.sv
module tlu_combine #(
    parameter int unsigned WIDTH = tlu_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a1,
    input  logic [WIDTH-1:0] b1,
    input  logic [WIDTH-1:0] c1,
    input  tlu_pkg::mode_e   mode,
    input  logic             flip_prod,
    input  logic             flip_gate,
    output logic [WIDTH-1:0] res
);
    import tlu_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prod, prod_f, gated_f, r;
        always_comb begin
            prod    = a1[i] & b1[i];
            prod_f  = prod ^ flip_prod;
            gated_f = (c1[i] & prod_f) ^ flip_gate;
            case (mode)
                MODE_GATED:  r = gated_f;
                MODE_XOR3:   r = a1[i] ^ b1[i] ^ c1[i];
                MODE_PXC:    r = prod ^ c1[i];
                MODE_SELECT: r = prod | (~a1[i] & c1[i]);
                default:     r = 1'b0;
            endcase
        end
        assign res[i] = r;
    end
endmodule

// File: rtl/tlu_out_stage.sv
module tlu_out_stage #(
    parameter int unsigned WIDTH   = tlu_pkg::DEF_WIDTH,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] d,
    output logic             q_valid,
    output logic [WIDTH-1:0] q
);
    if (REG_OUT) begin : g_reg
        logic             v_r;
        logic [WIDTH-1:0] q_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_r <= 1'b0;
                q_r <= '0;
            end else begin
                v_r <= in_valid;
                if (in_valid) q_r <= d;
            end
        end
        assign q_valid = v_r;
        assign q       = q_r;
    end else begin : g_comb
        assign q_valid = in_valid;
        assign q       = d;
    end
endmodule

// File: rtl/tri_logic_unit.sv
module tri_logic_unit #(
    parameter int unsigned WIDTH   = tlu_pkg::DEF_WIDTH,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [WIDTH-1:0]             opnd_a,
    input  logic [WIDTH-1:0]             opnd_b,
    input  logic [WIDTH-1:0]             opnd_c,
    input  logic [tlu_pkg::OPT_BITS-1:0] op_sel,
    output logic                         out_valid,
    output logic [WIDTH-1:0]             out_result
);
    import tlu_pkg::*;

    opt_t             opt;
    mode_e            mode;
    logic [WIDTH-1:0] a1, b1, c1, comb_res;

    assign opt  = opt_t'(op_sel);
    assign mode = decode_mode(opt);

    tlu_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .a(opnd_a), .b(opnd_b), .c(opnd_c), .opt(opt),
        .a1(a1), .b1(b1), .c1(c1)
    );

    tlu_combine #(.WIDTH(WIDTH)) u_comb (
        .a1(a1), .b1(b1), .c1(c1), .mode(mode),
        .flip_prod(opt.flip_prod), .flip_gate(opt.flip_gate),
        .res(comb_res)
    );

    tlu_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst(rst), .in_valid(in_valid), .d(comb_res),
        .q_valid(out_valid), .q(out_result)
    );

    if (REG_OUT) begin : g_chk
        assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_result));
        assert_and3_R10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 6'b100000) |=>
                out_result == $past(opnd_a & opnd_b & opnd_c));
        assert_or3_R10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 6'b110111) |=>
                out_result == $past(opnd_a | opnd_b | opnd_c));
        assert_xor3_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 6'b011000) |=>
                out_result == $past(opnd_a ^ opnd_b ^ opnd_c));
        assert_select_R5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 6'b000000) |=>
                out_result == $past((opnd_a & opnd_b) | (~opnd_a & opnd_c)));
    end
endmodule

// File: tb/tri_logic_unit_bench.sv
`timescale 1ns/1ps
module tri_logic_unit_bench;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] a = '0, b = '0, c = '0;
    logic [5:0]   op = '0;
    logic         out_valid;
    logic [W-1:0] out_result;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [W-1:0] val;
        string        req;
    } exp_t;
    exp_t exp_q[$];

    logic [W-1:0] last_res;
    bit           have_last = 0;
    bit           mon_en = 0;

    always #4 clk = ~clk;

    tri_logic_unit u_tri_logic_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(a), .opnd_b(b), .opnd_c(c), .op_sel(op),
        .out_valid(out_valid), .out_result(out_result)
    );

    // Scalar model written from the requirement text.
    function automatic logic ref_bit(logic x, logic y, logic z, logic [5:0] o);
        logic x1, y1, z1, d;
        x1 = o[0] ? ~x : x;
        y1 = o[1] ? ~y : y;
        z1 = o[2] ? ~z : z;
        d  = x1 & y1;
        if (o[5])                 return (z1 & (o[3] ? ~d : d)) ^ o[4];
        else if (o[4] && o[3])    return x1 ^ y1 ^ z1;
        else if (o[4])            return d ^ z1;
        else                      return d | (~x1 & z1);
    endfunction

    function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y,
                                           logic [W-1:0] z, logic [5:0] o);
        logic [7:0]   tt;
        logic [W-1:0] r;
        for (int k = 0; k < 8; k++) tt[k] = ref_bit(k[2], k[1], k[0], o);
        for (int i = 0; i < W; i++) r[i] = tt[{x[i], y[i], z[i]}];
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z,
                         logic [5:0] o, string req);
        exp_t e;
        @(negedge clk);
        a = x; b = y; c = z; op = o; in_valid = 1'b1;
        e.val = model(x, y, z, o);
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a = {$urandom, $urandom}; b = ~a; c = {$urandom, $urandom};
            op = 6'($urandom);
        end
    endtask

    // Monitor: compares results against the queue, and checks hold while idle.
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8: unexpected out_valid, actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.req, out_result, e.val);
                end
                last_res  = out_result;
                have_last = 1;
            end else if (have_last) begin
                check("R8 hold", out_result, last_res);
            end
        end
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] x, y, z;
        // R9: reset dominates even with the strobe high
        @(negedge clk);
        in_valid = 1'b1; a = '1; b = '1; c = '1; op = 6'b100000;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++; $display("FAIL R9: out_valid actual %b expected 0", out_valid);
        end
        check("R9", out_result, '0);
        in_valid = 1'b0;
        rst = 1'b0;
        mon_en = 1;
        idle(2);

        x = 64'hF0F0_CCCC_AAAA_0F0F; y = 64'h3C3C_5A5A_FF00_1234; z = 64'h0123_4567_89AB_CDEF;
        // R10 named encodings
        drive(x, y, z, 6'b100000, "R10 and3");
        drive(x, y, z, 6'b110111, "R10 or3");
        drive(x, y, z, 6'b011001, "R10 xnor3");
        // R5 select and R6 bit 3 ignored
        drive(x, y, z, 6'b000000, "R5 select");
        drive(x, y, z, 6'b001000, "R6 bit3 ignored");
        drive(x, y, z, 6'b001101, "R6 bit3 ignored inv");
        // R3, R4
        drive(x, y, z, 6'b011000, "R3 xor3");
        drive(x, y, z, 6'b010000, "R4 prod xor c");
        drive(x, y, z, 6'b010011, "R4 inverted operands");
        // R1 inversions
        drive(x, y, z, 6'b100001, "R1 invert a");
        drive(x, y, z, 6'b100010, "R1 invert b");
        drive(x, y, z, 6'b100100, "R1 invert c");
        // R2 gated chain with inversions
        drive(x, y, z, 6'b101000, "R2 flip product");
        drive(x, y, z, 6'b110000, "R2 flip gate");
        drive(x, y, z, 6'b111000, "R2 flip both");
        idle(3);
        // Edge patterns
        drive('0, '0, '0, 6'b110100, "R2 all zero");
        drive('1, '1, '1, 6'b000001, "R5 all ones");
        drive({32{2'b01}}, {32{2'b10}}, '1, 6'b011000, "R3 alternating");
        idle(1);
        // R7: walking one through the select path
        for (int i = 0; i < W; i += 7) begin
            drive(W'(1) << i, '1, '0, 6'b000000, "R7 walking bit");
        end
        idle(2);
        // Sweep every option value with random operands, some gaps for R8
        for (int o = 0; o < 64; o++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                  6'(o), "R2-mode sweep R8");
            if (o % 9 == 0) idle(1);
        end
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: pending results actual %0d expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule